// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the ready pools of an out-of-order core and its execution units. Each operation class has its own small pool of ready instructions, tagged by sequence number. Every cycle the selector grants up to `W` instructions, always taking the globally oldest eligible one first. A class whose functional unit is unavailable is passed over, so younger instructions in other classes still issue. Squashed entries are dropped from their pools without taking an issue slot.

Each class has one functional unit, described by a per-class issue latency. A latency of 0 or 1 means the unit is pipelined: it accepts a new operation every cycle and signals a release pulse in the cycle after issue. A latency `L > 1` means the unit is not pipelined. It stays reserved after issue, and `L-1` cycles later the operation is handed to execution through a completion pulse that carries its sequence number and frees the unit. Classes flagged as needing no unit ignore availability and are limited only by the issue width.

Sequence numbers are assumed unique and free of wrap-around within the window held in the pools. The allocator upstream is assumed never to write into a full pool.

Top module: `iss_sel_top`

## Requirements
- R1: Within a class, only the non-squashed entry with the smallest sequence number is eligible. An entry written in cycle t becomes eligible in cycle t+1, even when it is older than the current head.
- R2: Grants go out in ascending sequence-number order across all classes. Slot 0 carries the oldest grant, and at most `W` grants are made per cycle.
- R3: A class that needs a unit whose `fu_avail` bit is 0, or whose unit is reserved, gets no grant that cycle, and younger classes still issue. `cls_stall[c]` is 1 when such a class has an eligible entry that lost out only to unavailability: either fewer than `W` grants were made, or the entry is older than the last grant.
- R4: A squashed entry is never granted and uses no issue slot. It is removed from its pool at the next clock edge.
- R5: A class with a pipelined unit (latency 0 or 1) gets at most one grant per cycle, and `unit_rel[c]` is 1 in the cycle after that grant.
- R6: After a grant to a class with latency `L > 1`, the class gets no grant for `L-1` cycles. In the last of those cycles, `xfer_vld[c]` and `unit_rel[c]` are 1 and `xfer_seq` slice c holds the granted sequence number. The class can be granted again `L` cycles after the first grant.
- R7: A class with its `no_unit` bit set issues regardless of `fu_avail` and never raises `cls_stall`.
- R8: `issue_cnt` equals the number of set bits in `gnt_vld`, and the grant slots are filled from slot 0 upward with no gaps.
- R9: While `rst_n` is low at a clock edge, all pools and unit reservations are cleared. Afterwards `gnt_vld`, `issue_cnt`, `unit_rel` and `xfer_vld` are 0 until new entries arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_vld | input | 1 | Write a ready entry this cycle |
| ins_seq | input | SEQW | Sequence number of the written entry |
| ins_cls | input | CW | Operation class of the written entry |
| ins_sq | input | 1 | Written entry is already squashed |
| fu_avail | input | NCLS | Per-class external unit availability |
| no_unit | input | NCLS | Per-class flag: the class needs no functional unit |
| cls_lat | input | NCLS*LATW | Per-class issue latency, class c at bits [c*LATW +: LATW] |
| gnt_vld | output | W | Grant valid per issue slot |
| gnt_seq | output | W*SEQW | Granted sequence number per slot |
| gnt_cls | output | W*CW | Granted class per slot |
| issue_cnt | output | CNTW | Number of grants this cycle |
| unit_rel | output | NCLS | Unit release request per class |
| xfer_vld | output | NCLS | Long-latency handoff to execution per class |
| xfer_seq | output | NCLS*SEQW | Sequence number being handed off, per class |
| cls_stall | output | NCLS | Class passed over because its unit was unavailable |

## Verification
The assertions check, on every cycle, the properties that hold locally in time. Grants are packed from slot 0 and strictly ascending in age. The issue count matches the grant vector. No unit class is granted without availability or more than once per cycle. A pipelined grant is followed by a release. No grant coincides with a pending long-latency handoff. Only the bench scenarios can show the cross-cycle behaviour: that the oldest eligible instruction is actually the one chosen, that squashed entries silently vanish, that an older late write overtakes an existing head, and that a non-pipelined unit frees exactly `L` cycles after issue with the correct handed-off sequence number.

// File: rtl/iss_pkg.sv
// Shared defaults and helpers for the issue selector.
// Assumes: sequence numbers compare as plain unsigned values (no wrap).
package iss_pkg;
    localparam int DEF_NCLS  = 4;   // operation classes
    localparam int DEF_DEPTH = 4;   // ready entries per class pool
    localparam int DEF_SEQW  = 8;   // sequence number width
    localparam int DEF_W     = 2;   // issue width
    localparam int DEF_LATW  = 3;   // issue latency field width

    // Width of a counter that holds values 0..n.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/iss_pool.sv
// Per-class ready pool: unordered slots holding sequence number and squash flag.
// Assumes: upstream never writes into a full pool; squashed slots drop every cycle.
module iss_pool #(
    parameter int DEPTH = iss_pkg::DEF_DEPTH,
    parameter int SEQW  = iss_pkg::DEF_SEQW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEQW-1:0]             wr_seq,
    input  logic                        wr_sq,
    input  logic [DEPTH-1:0]            take,
    output logic [DEPTH-1:0]            vld,
    output logic [DEPTH-1:0]            sq,
    output logic [DEPTH-1:0][SEQW-1:0]  seq
);
    logic [DEPTH-1:0] wsel;

    // Pick the lowest free slot for an incoming write.
    always_comb begin
        wsel = '0;
        for (int d = 0; d < DEPTH; d++) begin
            if (!vld[d] && wsel == '0) wsel[d] = 1'b1;
        end
    end

    // Slot update: write, or release on grant or squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            sq  <= '0;
            seq <= '0;
        end else begin
            for (int d = 0; d < DEPTH; d++) begin
                if (wr_en && wsel[d]) begin
                    vld[d] <= 1'b1;
                    sq[d]  <= wr_sq;
                    seq[d] <= wr_seq;
                end else if (take[d] || sq[d]) begin
                    vld[d] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/iss_unit.sv
// Per-class functional unit tracker: release timing and long-latency handoff.
// Assumes: issue is only raised while free is 1; latency 0 or 1 means pipelined.
module iss_unit #(
    parameter int SEQW = iss_pkg::DEF_SEQW,
    parameter int LATW = iss_pkg::DEF_LATW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [LATW-1:0] lat,
    input  logic [SEQW-1:0] seq,
    input  logic            avail,
    output logic            free,
    output logic            rel,
    output logic            xfer_vld,
    output logic [SEQW-1:0] xfer_seq
);
    logic [LATW-1:0] left_q;
    logic            pipe_q;
    logic [SEQW-1:0] hold_q;

    // Reservation countdown and pipelined release flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            pipe_q <= 1'b0;
            hold_q <= '0;
        end else begin
            pipe_q <= issue && (lat <= LATW'(1));
            if (issue && (lat > LATW'(1))) begin
                left_q <= lat - LATW'(1);
                hold_q <= seq;
            end else if (left_q != '0) begin
                left_q <= left_q - LATW'(1);
            end
        end
    end

    // Availability and completion outputs.
    always_comb begin
        free     = avail && (left_q == '0);
        xfer_vld = (left_q == LATW'(1));
        xfer_seq = hold_q;
        rel      = pipe_q || xfer_vld;
    end
endmodule

// File: rtl/iss_pick.sv
// Oldest-first picker: W rounds, each taking the oldest eligible entry of any class.
// Assumes: unique sequence numbers; a unit class issues at most once per cycle.
module iss_pick #(
    parameter int NCLS  = iss_pkg::DEF_NCLS,
    parameter int DEPTH = iss_pkg::DEF_DEPTH,
    parameter int SEQW  = iss_pkg::DEF_SEQW,
    parameter int W     = iss_pkg::DEF_W,
    localparam int N    = NCLS * DEPTH,
    localparam int CW   = $clog2(NCLS),
    localparam int CNTW = iss_pkg::cnt_bits(W)
) (
    input  logic [N-1:0]             e_vld,
    input  logic [N-1:0]             e_sq,
    input  logic [N-1:0][SEQW-1:0]   e_seq,
    input  logic [NCLS-1:0]          unit_free,
    input  logic [NCLS-1:0]          no_unit,
    output logic [N-1:0]             e_take,
    output logic [NCLS-1:0]          cls_gnt,
    output logic [NCLS*SEQW-1:0]     cls_gseq,
    output logic [W-1:0]             gnt_vld,
    output logic [W*SEQW-1:0]        gnt_seq,
    output logic [W*CW-1:0]          gnt_cls,
    output logic [CNTW-1:0]          issue_cnt,
    output logic [NCLS-1:0]          cls_stall
);
    logic            found;
    int              bidx;
    logic [SEQW-1:0] bseq;
    logic [SEQW-1:0] last_seq;
    logic            older;

    // Grant rounds followed by stall classification.
    always_comb begin
        e_take    = '0;
        cls_gnt   = '0;
        cls_gseq  = '0;
        gnt_vld   = '0;
        gnt_seq   = '0;
        gnt_cls   = '0;
        issue_cnt = '0;
        cls_stall = '0;
        last_seq  = '0;
        found     = 1'b0;
        bidx      = 0;
        bseq      = '0;
        older     = 1'b0;
        for (int r = 0; r < W; r++) begin
            found = 1'b0;
            bidx  = 0;
            bseq  = '0;
            for (int e = 0; e < N; e++) begin
                if (e_vld[e] && !e_sq[e] && !e_take[e] &&
                    (no_unit[e / DEPTH] || (unit_free[e / DEPTH] && !cls_gnt[e / DEPTH])) &&
                    (!found || (e_seq[e] < bseq))) begin
                    found = 1'b1;
                    bidx  = e;
                    bseq  = e_seq[e];
                end
            end
            if (found) begin
                e_take[bidx]                          = 1'b1;
                cls_gnt[bidx / DEPTH]                 = 1'b1;
                cls_gseq[(bidx / DEPTH) * SEQW +: SEQW] = bseq;
                gnt_vld[r]                            = 1'b1;
                gnt_seq[r * SEQW +: SEQW]             = bseq;
                gnt_cls[r * CW +: CW]                 = CW'(bidx / DEPTH);
                issue_cnt                             = issue_cnt + CNTW'(1);
                last_seq                              = bseq;
            end
        end
        for (int c = 0; c < NCLS; c++) begin
            older = 1'b0;
            for (int d = 0; d < DEPTH; d++) begin
                if (e_vld[c * DEPTH + d] && !e_sq[c * DEPTH + d] &&
                    ((int'(issue_cnt) < W) || (e_seq[c * DEPTH + d] < last_seq)))
                    older = 1'b1;
            end
            cls_stall[c] = older && !no_unit[c] && !unit_free[c];
        end
    end
endmodule

// File: rtl/iss_sel_top.sv
// Issue selector top: per-class pools and unit trackers around one oldest-first picker.
// Assumes: NCLS >= 2; at most one ready-entry write per cycle.
module iss_sel_top #(
    parameter int NCLS  = iss_pkg::DEF_NCLS,
    parameter int DEPTH = iss_pkg::DEF_DEPTH,
    parameter int SEQW  = iss_pkg::DEF_SEQW,
    parameter int W     = iss_pkg::DEF_W,
    parameter int LATW  = iss_pkg::DEF_LATW,
    localparam int N    = NCLS * DEPTH,
    localparam int CW   = $clog2(NCLS),
    localparam int CNTW = iss_pkg::cnt_bits(W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ins_vld,
    input  logic [SEQW-1:0]       ins_seq,
    input  logic [CW-1:0]         ins_cls,
    input  logic                  ins_sq,
    input  logic [NCLS-1:0]       fu_avail,
    input  logic [NCLS-1:0]       no_unit,
    input  logic [NCLS*LATW-1:0]  cls_lat,
    output logic [W-1:0]          gnt_vld,
    output logic [W*SEQW-1:0]     gnt_seq,
    output logic [W*CW-1:0]       gnt_cls,
    output logic [CNTW-1:0]       issue_cnt,
    output logic [NCLS-1:0]       unit_rel,
    output logic [NCLS-1:0]       xfer_vld,
    output logic [NCLS*SEQW-1:0]  xfer_seq,
    output logic [NCLS-1:0]       cls_stall
);
    logic [N-1:0]           e_vld;
    logic [N-1:0]           e_sq;
    logic [N-1:0][SEQW-1:0] e_seq;
    logic [N-1:0]           e_take;
    logic [NCLS-1:0]        unit_free;
    logic [NCLS-1:0]        cls_gnt;
    logic [NCLS*SEQW-1:0]   cls_gseq;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        iss_pool #(.DEPTH(DEPTH), .SEQW(SEQW)) i_pool (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ins_vld && (ins_cls == CW'(c))),
            .wr_seq (ins_seq),
            .wr_sq  (ins_sq),
            .take   (e_take[c * DEPTH +: DEPTH]),
            .vld    (e_vld[c * DEPTH +: DEPTH]),
            .sq     (e_sq[c * DEPTH +: DEPTH]),
            .seq    (e_seq[c * DEPTH +: DEPTH])
        );

        iss_unit #(.SEQW(SEQW), .LATW(LATW)) i_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue    (cls_gnt[c] && !no_unit[c]),
            .lat      (cls_lat[c * LATW +: LATW]),
            .seq      (cls_gseq[c * SEQW +: SEQW]),
            .avail    (fu_avail[c]),
            .free     (unit_free[c]),
            .rel      (unit_rel[c]),
            .xfer_vld (xfer_vld[c]),
            .xfer_seq (xfer_seq[c * SEQW +: SEQW])
        );
    end

    iss_pick #(.NCLS(NCLS), .DEPTH(DEPTH), .SEQW(SEQW), .W(W)) i_pick (
        .e_vld     (e_vld),
        .e_sq      (e_sq),
        .e_seq     (e_seq),
        .unit_free (unit_free),
        .no_unit   (no_unit),
        .e_take    (e_take),
        .cls_gnt   (cls_gnt),
        .cls_gseq  (cls_gseq),
        .gnt_vld   (gnt_vld),
        .gnt_seq   (gnt_seq),
        .gnt_cls   (gnt_cls),
        .issue_cnt (issue_cnt),
        .cls_stall (cls_stall)
    );
endmodule

// File: rtl/iss_sel_chk.sv
// Port-level property checker for the issue selector, bound to every instance.
module iss_sel_chk #(
    parameter int NCLS  = iss_pkg::DEF_NCLS,
    parameter int SEQW  = iss_pkg::DEF_SEQW,
    parameter int W     = iss_pkg::DEF_W,
    parameter int LATW  = iss_pkg::DEF_LATW,
    localparam int CW   = $clog2(NCLS),
    localparam int CNTW = iss_pkg::cnt_bits(W)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [W-1:0]         gnt_vld,
    input logic [W*SEQW-1:0]    gnt_seq,
    input logic [W*CW-1:0]      gnt_cls,
    input logic [CNTW-1:0]      issue_cnt,
    input logic [NCLS-1:0]      fu_avail,
    input logic [NCLS-1:0]      no_unit,
    input logic [NCLS*LATW-1:0] cls_lat,
    input logic [NCLS-1:0]      unit_rel,
    input logic [NCLS-1:0]      xfer_vld
);
    int cg_num [NCLS];

    // Count grants per class from the slot outputs.
    always_comb begin
        for (int c = 0; c < NCLS; c++) begin
            cg_num[c] = 0;
            for (int r = 0; r < W; r++) begin
                if (gnt_vld[r] && (gnt_cls[r * CW +: CW] == CW'(c))) cg_num[c] = cg_num[c] + 1;
            end
        end
    end

    AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        int'(issue_cnt) == $countones(gnt_vld)); // R8

    for (genvar r = 1; r < W; r++) begin : g_slot
        AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[r] |-> gnt_vld[r-1]); // R8
        AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[r] |-> (gnt_seq[(r-1) * SEQW +: SEQW] < gnt_seq[r * SEQW +: SEQW])); // R2
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        AST_NEED_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
            (cg_num[c] != 0 && !no_unit[c]) |-> fu_avail[c]); // R3
        AST_ONE_PER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            !no_unit[c] |-> (cg_num[c] <= 1)); // R5
        AST_PIPE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (cg_num[c] != 0 && !no_unit[c] && cls_lat[c * LATW +: LATW] <= LATW'(1))
            |=> unit_rel[c]); // R5
        AST_HELD_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_vld[c] && !no_unit[c]) |-> (cg_num[c] == 0)); // R6
    end
endmodule

bind iss_sel_top iss_sel_chk #(
    .NCLS(NCLS), .SEQW(SEQW), .W(W), .LATW(LATW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_vld   (gnt_vld),
    .gnt_seq   (gnt_seq),
    .gnt_cls   (gnt_cls),
    .issue_cnt (issue_cnt),
    .fu_avail  (fu_avail),
    .no_unit   (no_unit),
    .cls_lat   (cls_lat),
    .unit_rel  (unit_rel),
    .xfer_vld  (xfer_vld)
);

// File: tb/test_iss_sel_top.sv
`timescale 1ns/1ps
module test_iss_sel_top;
    localparam int NCLS = 4, SEQW = 8, W = 2, LATW = 3, CW = 2, CNTW = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ins_vld = 1'b0;
    logic [SEQW-1:0]      ins_seq = '0;
    logic [CW-1:0]        ins_cls = '0;
    logic                 ins_sq = 1'b0;
    logic [NCLS-1:0]      fu_avail = '0;
    logic [NCLS-1:0]      no_unit = 4'b1000;
    logic [NCLS*LATW-1:0] cls_lat = 12'h249;
    logic [W-1:0]         gnt_vld;
    logic [W*SEQW-1:0]    gnt_seq;
    logic [W*CW-1:0]      gnt_cls;
    logic [CNTW-1:0]      issue_cnt;
    logic [NCLS-1:0]      unit_rel;
    logic [NCLS-1:0]      xfer_vld;
    logic [NCLS*SEQW-1:0] xfer_seq;
    logic [NCLS-1:0]      cls_stall;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iss_sel_top i_iss_sel_top (
        .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_seq(ins_seq),
        .ins_cls(ins_cls), .ins_sq(ins_sq), .fu_avail(fu_avail), .no_unit(no_unit),
        .cls_lat(cls_lat), .gnt_vld(gnt_vld), .gnt_seq(gnt_seq), .gnt_cls(gnt_cls),
        .issue_cnt(issue_cnt), .unit_rel(unit_rel), .xfer_vld(xfer_vld),
        .xfer_seq(xfer_seq), .cls_stall(cls_stall)
    );

    typedef struct packed {
        logic       iv;
        logic [7:0] seq;
        logic [1:0] cls;
        logic       sq;
        logic [3:0] av;
        logic [1:0] cnt;
        logic [7:0] s0;
        logic [7:0] s1;
        logic [3:0] tg;
    } vec_t;

    // Each row: write applied at the coming edge; expected grants from the current contents.
    localparam vec_t VEC [29] = '{
        '{1'b1, 8'd10, 2'd0, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd9}, // R9 empty
        '{1'b1, 8'd7,  2'd1, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd3}, // R3 blocked
        '{1'b1, 8'd12, 2'd0, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd3},
        '{1'b1, 8'd3,  2'd2, 1'b1, 4'h0, 2'd0, 8'd0,  8'd0,  4'd3},
        '{1'b1, 8'd9,  2'd3, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd4}, // R4 squashed 3 not granted
        '{1'b0, 8'd0,  2'd0, 1'b0, 4'h0, 2'd1, 8'd9,  8'd0,  4'd7}, // R7 no-unit class
        '{1'b1, 8'd4,  2'd3, 1'b0, 4'hF, 2'd2, 8'd7,  8'd10, 4'd2}, // R2 oldest two
        '{1'b0, 8'd0,  2'd0, 1'b0, 4'hF, 2'd2, 8'd4,  8'd12, 4'd2},
        '{1'b1, 8'd30, 2'd0, 1'b0, 4'hF, 2'd0, 8'd0,  8'd0,  4'd8},
        '{1'b1, 8'd31, 2'd0, 1'b0, 4'hF, 2'd1, 8'd30, 8'd0,  4'd1}, // R1 next cycle
        '{1'b1, 8'd8,  2'd1, 1'b0, 4'hF, 2'd1, 8'd31, 8'd0,  4'd1},
        '{1'b1, 8'd40, 2'd2, 1'b0, 4'hF, 2'd1, 8'd8,  8'd0,  4'd2},
        '{1'b1, 8'd41, 2'd2, 1'b0, 4'hF, 2'd1, 8'd40, 8'd0,  4'd2},
        '{1'b1, 8'd2,  2'd0, 1'b0, 4'hF, 2'd1, 8'd41, 8'd0,  4'd2},
        '{1'b1, 8'd42, 2'd2, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd3},
        '{1'b1, 8'd43, 2'd2, 1'b0, 4'h4, 2'd1, 8'd42, 8'd0,  4'd3}, // R3 younger passes blocked
        '{1'b0, 8'd0,  2'd0, 1'b0, 4'h4, 2'd1, 8'd43, 8'd0,  4'd3},
        '{1'b1, 8'd50, 2'd2, 1'b0, 4'h5, 2'd1, 8'd2,  8'd0,  4'd3},
        '{1'b1, 8'd51, 2'd2, 1'b0, 4'h5, 2'd1, 8'd50, 8'd0,  4'd5}, // R5 one per unit
        '{1'b1, 8'd60, 2'd3, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd3},
        '{1'b1, 8'd61, 2'd3, 1'b0, 4'h0, 2'd1, 8'd60, 8'd0,  4'd7},
        '{1'b1, 8'd70, 2'd1, 1'b0, 4'h0, 2'd1, 8'd61, 8'd0,  4'd7},
        '{1'b1, 8'd65, 2'd1, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd3},
        '{1'b0, 8'd0,  2'd0, 1'b0, 4'hF, 2'd2, 8'd51, 8'd65, 4'd1}, // R1 late older write wins
        '{1'b0, 8'd0,  2'd0, 1'b0, 4'hF, 2'd1, 8'd70, 8'd0,  4'd1},
        '{1'b1, 8'd80, 2'd0, 1'b0, 4'h0, 2'd0, 8'd0,  8'd0,  4'd4},
        '{1'b1, 8'd75, 2'd0, 1'b1, 4'h0, 2'd0, 8'd0,  8'd0,  4'd4},
        '{1'b0, 8'd0,  2'd0, 1'b0, 4'hF, 2'd1, 8'd80, 8'd0,  4'd4}, // R4 squashed older skipped
        '{1'b0, 8'd0,  2'd0, 1'b0, 4'hF, 2'd0, 8'd0,  8'd0,  4'd4}
    };

    function automatic string tag_of(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic v, input int s, input int c, input logic q);
        ins_vld = v;
        ins_seq = SEQW'(s);
        ins_cls = CW'(c);
        ins_sq  = q;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9", int'(gnt_vld), 0);
        chk("R9", int'(issue_cnt), 0);
        chk("R9", int'(unit_rel), 0);
        chk("R9", int'(xfer_vld), 0);

        foreach (VEC[i]) begin
            put(VEC[i].iv, int'(VEC[i].seq), int'(VEC[i].cls), VEC[i].sq);
            fu_avail = VEC[i].av;
            #1;
            chk({tag_of(int'(VEC[i].tg)), " count"}, int'(issue_cnt), int'(VEC[i].cnt));
            chk("R8 count vs slots", $countones(gnt_vld), int'(VEC[i].cnt));
            if (VEC[i].cnt >= 2'd1) chk({tag_of(int'(VEC[i].tg)), " slot0"}, int'(gnt_seq[7:0]), int'(VEC[i].s0));
            if (VEC[i].cnt >= 2'd2) chk({tag_of(int'(VEC[i].tg)), " slot1"}, int'(gnt_seq[15:8]), int'(VEC[i].s1));
            tick();
        end

        // R6 non-pipelined class 0 with latency 3
        cls_lat = 12'h24B;
        fu_avail = 4'hF;
        put(1'b1, 100, 0, 1'b0);
        tick();
        put(1'b1, 101, 0, 1'b0);
        #1;
        chk("R6 first grant", int'(gnt_seq[7:0]), 100);
        chk("R6 first count", int'(issue_cnt), 1);
        tick();
        put(1'b0, 0, 0, 1'b0);
        #1;
        chk("R6 held count", int'(issue_cnt), 0);
        chk("R6 no xfer yet", int'(xfer_vld[0]), 0);
        tick();
        #1;
        chk("R6 xfer valid", int'(xfer_vld[0]), 1);
        chk("R6 xfer seq", int'(xfer_seq[7:0]), 100);
        chk("R6 release", int'(unit_rel[0]), 1);
        chk("R6 still held", int'(issue_cnt), 0);
        tick();
        #1;
        chk("R6 regrant count", int'(issue_cnt), 1);
        chk("R6 regrant seq", int'(gnt_seq[7:0]), 101);
        tick();
        repeat (3) tick();
        cls_lat = 12'h249;

        // R5 pipelined class 1: one per cycle, release next cycle
        fu_avail = 4'b1101;
        put(1'b1, 110, 1, 1'b0);
        tick();
        put(1'b1, 111, 1, 1'b0);
        tick();
        put(1'b0, 0, 0, 1'b0);
        fu_avail = 4'hF;
        #1;
        chk("R5 single grant", int'(issue_cnt), 1);
        chk("R5 oldest first", int'(gnt_seq[7:0]), 110);
        tick();
        #1;
        chk("R5 release pulse", int'(unit_rel[1]), 1);
        chk("R5 second grant", int'(gnt_seq[7:0]), 111);
        tick();
        tick();
        #1;
        chk("R5 release cleared", int'(unit_rel[1]), 0);

        // R3 stall flag for a blocked class
        fu_avail = 4'b1011;
        put(1'b1, 120, 2, 1'b0);
        tick();
        put(1'b0, 0, 0, 1'b0);
        #1;
        chk("R3 stall flag", int'(cls_stall[2]), 1);
        chk("R3 no grant", int'(issue_cnt), 0);
        fu_avail = 4'hF;
        #1;
        chk("R3 stall cleared", int'(cls_stall[2]), 0);
        chk("R3 grant on avail", int'(gnt_seq[7:0]), 120);
        tick();

        // R7 no-unit class never stalls when availability is low
        fu_avail = 4'h0;
        put(1'b1, 130, 3, 1'b0);
        tick();
        put(1'b0, 0, 0, 1'b0);
        #1;
        chk("R7 grant without unit", int'(gnt_seq[7:0]), 130);
        chk("R7 no stall", int'(cls_stall[3]), 0);
        tick();

        finish_run();
    end
endmodule